// File: doc/BRIEF.md
# Ripple-Through Elastic FIFO

This block is a small elastic queue for passing words between a producer and a consumer that run at unrelated rates. It stores up to sixteen 4-bit words in a chain of stages. Each stage holds one word and a presence bit. A word written at the head of the chain moves one stage per clock toward the tail, as long as the next stage is empty. Free slots therefore drift back toward the head. No read or write pointers exist.

The producer raises `shift_in` to offer `din`. It watches `in_ready`, which is high only while the head stage is free. The consumer watches `out_ready`, which is high while the tail stage holds a word. It takes that word by raising `shift_out`. Both strobes are level signals from outside the clock domain. They pass through a two-flop synchroniser and act on their rising edge. The output word can be masked with an active-low enable.

Top module: `bubble_fifo`

## Requirements
- R1: Words leave in the order they were accepted, and up to DEPTH (16) words of WIDTH (4) bits are held at once.
- R2: `in_ready` is high exactly when the head stage is empty. It goes low after an accepted shift-in.
- R3: `out_ready` is high exactly when the tail stage holds a word. While it is high, `dout` shows that word (when enabled).
- R4: A rising edge of `shift_in` while `in_ready` is high loads `din` into the head stage. That word stays in the head stage for as long as `shift_in` remains high.
- R5: A rising edge of `shift_in` while the queue is full is ignored. `in_ready` stays low, and the queue still delivers exactly the 16 stored words.
- R6: A rising edge of `shift_out` empties the tail stage and drops `out_ready`. The tail is refilled only after `shift_out` is low again. If no word remains, `out_ready` stays low.
- R7: `dout` changes only when a new word enters the tail stage. Once the queue is empty, it keeps showing the last word taken.
- R8: While `rst` is high, every stage is marked empty: `in_ready` is 1 and `out_ready` is 0. The word shown on `dout` is not altered.
- R9: If `shift_in` is already high when `rst` falls, `din` is loaded into the head stage after reset ends.
- R10: When `out_en_n` is 1, `dout` is all zeros and `dout_off` is 1. When `out_en_n` is 0, `dout_off` is 0 and `dout` shows the tail word.
- R11: A word advances at most one stage per clock. In an empty queue it takes at least DEPTH-1 clocks after `shift_in` falls to reach the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high |
| shift_in | input | 1 | Write strobe, acts on its rising edge |
| shift_out | input | 1 | Read strobe, acts on its rising edge |
| din | input | WIDTH | Word to write |
| out_en_n | input | 1 | Output enable, active low |
| dout | output | WIDTH | Tail word, or zero when disabled |
| in_ready | output | 1 | Head stage free |
| out_ready | output | 1 | Tail stage holds a word |
| dout_off | output | 1 | High while the output is masked |

## Verification
The following properties are checked on every clock by assertions:
- A word is held in the head stage while the write strobe is high.
- The tail stays empty while the read strobe is held high.
- A pop clears `out_ready` on the next cycle.
- The stored count never grows by more than one per clock.
- `dout` changes only when `out_ready` rises.
- Reset clears both flags.

The bench scenarios cover what a single-cycle property cannot show:
- Ordering across a whole fill and drain.
- The ignored write into a full queue.
- The load that follows a reset with the write strobe held high.
- The minimum ripple latency through the chain.

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic             shift_out,
  input  logic [WIDTH-1:0] din,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] dout,
  output logic             in_ready,
  output logic             out_ready,
  output logic             dout_off
);
  localparam int TAIL = DEPTH - 1;

  logic [DEPTH-1:0] mark, mark_nxt, move;
  logic [WIDTH-1:0] word [DEPTH];
  logic si_meta, si_hold, si_prev, so_meta, so_hold, so_prev;
  logic si_rise, so_rise, load, pop;

  always_ff @(posedge clk) begin
    si_meta <= shift_in;
    si_hold <= si_meta;
    so_meta <= shift_out;
    so_hold <= so_meta;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      si_prev <= 1'b0;
      so_prev <= 1'b0;
    end else begin
      si_prev <= si_hold;
      so_prev <= so_hold;
    end
  end

  assign si_rise = si_hold & ~si_prev;
  assign so_rise = so_hold & ~so_prev;
  assign load    = ~rst & si_rise & ~mark[0];
  assign pop     = ~rst & so_rise & mark[TAIL];

  always_comb begin
    move = '0;
    for (int k = 1; k < DEPTH; k++) begin
      move[k] = ~rst & mark[k-1] & ~mark[k];
      if (k == 1 && si_hold) move[k] = 1'b0;
      if (k == TAIL && so_hold) move[k] = 1'b0;
    end
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      mark_nxt[k] = mark[k];
      if (k < TAIL && move[k+1]) mark_nxt[k] = 1'b0;
      if (k > 0 && move[k]) mark_nxt[k] = 1'b1;
    end
    if (load) mark_nxt[0] = 1'b1;
    if (pop) mark_nxt[TAIL] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) mark <= '0;
    else     mark <= mark_nxt;
  end

  always_ff @(posedge clk) begin
    if (load) word[0] <= din;
    for (int k = 1; k < DEPTH; k++)
      if (move[k]) word[k] <= word[k-1];
  end

  assign in_ready  = ~mark[0];
  assign out_ready = mark[TAIL];
  assign dout      = out_en_n ? '0 : word[TAIL];
  assign dout_off  = out_en_n;
endmodule

// File: rtl/bubble_fifo_chk.sv
module bubble_fifo_chk #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [DEPTH-1:0] mark,
  input logic             si_hold,
  input logic             so_hold,
  input logic             so_rise,
  input logic             in_ready,
  input logic             out_ready,
  input logic             out_en_n,
  input logic [WIDTH-1:0] dout
);
  p_reset_flags_r8: assert property (@(posedge clk)
    rst |=> (in_ready && !out_ready));

  p_hold_head_r4: assert property (@(posedge clk) disable iff (rst)
    (si_hold && mark[0]) |=> mark[0]);

  p_pop_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (so_rise && out_ready) |=> !out_ready);

  p_refill_waits_r6: assert property (@(posedge clk) disable iff (rst)
    (so_hold && !out_ready) |=> !out_ready);

  p_one_step_r11: assert property (@(posedge clk) disable iff (rst)
    $countones(mark) <= $past($countones(mark)) + 1);

  p_dout_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!out_en_n && $past(!out_en_n) && !$rose(out_ready)) |-> $stable(dout));
endmodule

bind bubble_fifo bubble_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .mark(mark), .si_hold(si_hold), .so_hold(so_hold),
  .so_rise(so_rise), .in_ready(in_ready), .out_ready(out_ready),
  .out_en_n(out_en_n), .dout(dout)
);

// File: tb/bubble_fifo_tb_top.sv
module bubble_fifo_tb_top;
  localparam int W = 4;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_in = 1'b0, shift_out = 1'b0, out_en_n = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic in_ready, out_ready, dout_off;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bubble_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .shift_in(shift_in), .shift_out(shift_out),
    .din(din), .out_en_n(out_en_n), .dout(dout), .in_ready(in_ready),
    .out_ready(out_ready), .dout_off(dout_off)
  );

  // op[9:8]: 0 = push data[7:4], 1 = pop and expect data[3:0]
  localparam logic [9:0] VEC [12] = '{
    {2'd0, 4'h3, 4'h0}, {2'd0, 4'hA, 4'h0}, {2'd0, 4'h5, 4'h0},
    {2'd1, 4'h0, 4'h3}, {2'd0, 4'hC, 4'h0}, {2'd1, 4'h0, 4'hA},
    {2'd0, 4'h0, 4'h0}, {2'd1, 4'h0, 4'h5}, {2'd1, 4'h0, 4'hC},
    {2'd0, 4'hF, 4'h0}, {2'd1, 4'h0, 4'h0}, {2'd1, 4'h0, 4'hF}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(logic [W-1:0] d);
    for (int i = 0; i < 100 && !in_ready; i++) tick(1);
    check("R2 ready before push", in_ready, 1);
    din = d;
    shift_in = 1'b1;
    tick(5);
    check("R4 busy while strobe high", in_ready, 0);
    shift_in = 1'b0;
    tick(5);
  endtask

  task automatic pop(logic [W-1:0] e);
    for (int i = 0; i < 100 && !out_ready; i++) tick(1);
    check("R3 word ready", out_ready, 1);
    check("R1 order", dout, e);
    shift_out = 1'b1;
    tick(6);
    check("R6 out_ready low after pop", out_ready, 0);
    shift_out = 1'b0;
    tick(D + 6);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    tick(4);
    rst = 1'b0;
    tick(2);
    check("R8 reset in_ready", in_ready, 1);
    check("R8 reset out_ready", out_ready, 0);
    check("R10 enabled dout_off", dout_off, 0);

    foreach (VEC[i]) begin
      if (VEC[i][9:8] == 2'd0) push(VEC[i][7:4]);
      else pop(VEC[i][3:0]);
    end

    // R11: ripple latency through an empty chain
    din = 4'h6;
    shift_in = 1'b1;
    tick(5);
    shift_in = 1'b0;
    tick(8);
    check("R11 not yet at tail", out_ready, 0);
    tick(20);
    check("R11 reached tail", out_ready, 1);
    pop(4'h6);

    // R5: fill to capacity, extra write ignored
    for (int k = 0; k < D; k++) push(W'(k));
    tick(30);
    check("R5 full in_ready", in_ready, 0);
    check("R3 full out_ready", out_ready, 1);
    din = 4'h9;
    shift_in = 1'b1;
    tick(5);
    shift_in = 1'b0;
    tick(10);
    check("R5 ignored write in_ready", in_ready, 0);
    for (int k = 0; k < D; k++) pop(W'(k));
    tick(30);
    check("R5 no extra word", out_ready, 0);
    check("R7 last word held", dout, D - 1);
    check("R2 empty in_ready", in_ready, 1);

    // R10: output masking
    out_en_n = 1'b1;
    tick(1);
    check("R10 masked dout", dout, 0);
    check("R10 dout_off", dout_off, 1);
    out_en_n = 1'b0;
    tick(1);
    check("R10 unmasked dout", dout, D - 1);

    // R8: reset with data, output word unchanged
    push(4'hB);
    push(4'h2);
    tick(30);
    held = dout;
    check("R8 pre-reset word", held, 4'hB);
    rst = 1'b1;
    tick(3);
    check("R8 in_ready in reset", in_ready, 1);
    check("R8 out_ready in reset", out_ready, 0);
    check("R8 dout kept", dout, held);
    rst = 1'b0;
    tick(30);
    check("R8 empty after reset", out_ready, 0);

    // R9: strobe held across reset release
    rst = 1'b1;
    din = 4'hD;
    shift_in = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(6);
    check("R9 loaded after reset", in_ready, 0);
    shift_in = 1'b0;
    tick(30);
    check("R9 word at tail", out_ready, 1);
    check("R9 word value", dout, 4'hD);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule